// File: doc/BRIEF.md
# Linked Breakpoint Match Unit

This block keeps six breakpoint slots, each made of a 32-bit compare value and a 32-bit control word. Every cycle it compares all slots against the current instruction address, the current context ID and the privilege of the access. It raises a single breakpoint event naming the lowest-numbered slot that hit. Slots 4 and 5 may hold a context ID instead of an address. An address slot can be chained through its link field to one of those context slots. It then fires only when both the address and the context ID match in the same cycle. Several address slots may share one context slot.

Software programs the slots through a small indexed access port. An access is accepted only when the requester is privileged and the debug-mode field selects monitor mode (binary 10). Any other access returns an undefined-access flag, reads as zero and leaves every slot unchanged. The event and read-data outputs are combinational from the stored slots and the current inputs. Slot writes are registered, so a write acts on the compare from the cycle after it is accepted.

Top module: `bp_match_unit`

## Requirements
- R1: After reset every control and value word is zero, so no event is raised (bp_hit=0, bp_idx=0) and accepted reads return zero.
- R2: An access is accepted only when priv=1, dbg_mode=2'b10 and acc_idx<6. Otherwise, with acc_en=1, acc_undef is 1, acc_rdata is 0 and no slot changes. An accepted access has acc_undef=0 and returns the selected word (acc_sel=0 control, acc_sel=1 value).
- R3: Control bits other than 0, 2:1, 8:5, 19:16, 20 and 21 read as zero whatever is written. Bit 21 reads as zero for slots 0 to 3.
- R4: A written word takes part in matching from the cycle after the write is accepted, and not in the cycle of the write.
- R5: Control bit 0 enables a slot. With control bits 21:20=00, an enabled slot hits when iva[31:2] equals value[31:2] and byte-select bit (5+iva[1:0]) is set. Byte select 0000 never hits.
- R6: The privilege filter is control bits 2:1. 01 passes privileged accesses only, 10 passes user accesses only, 11 passes both, and 00 passes none.
- R7: With bits 21:20=10 (slots 4 and 5 only), an enabled slot hits when ctx equals its full value, its byte select is 1111 and its filter passes. This hit is suppressed when priv=1 and dbg_mode=2'b10.
- R8: With bits 21:20=01, a slot hits when it is enabled, its address matches and its own filter passes, and its link target (bits 19:16) is enabled, configured 11, and its value equals ctx with byte select 1111. The filter of the target is ignored.
- R9: A linked slot whose target is itself, is not 4 or 5, or is not configured 11 never hits.
- R10: When several slots hit, bp_idx is the lowest hitting index. When none hits, bp_hit=0 and bp_idx=0.
- R11: A slot configured 11 never raises an event by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = control word, 1 = value word |
| acc_idx | input | 3 | Slot index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero unless accepted |
| acc_undef | output | 1 | Access refused |
| priv | input | 1 | Current access is privileged |
| dbg_mode | input | 2 | Debug mode field, 2'b10 = monitor |
| iva | input | 32 | Current instruction address |
| ctx | input | 32 | Current context ID |
| bp_hit | output | 1 | Breakpoint event this cycle |
| bp_idx | output | 3 | Lowest slot that hit |

## Verification
The bench drives the byte-select lanes one at a time, so a design that compared whole words, or picked the wrong lane, would miss the byte offset or fire on a neighbouring byte. It chains an address slot to a context slot and then breaks the chain in each way that matters: the target disabled, the target linked to itself, a target that cannot hold a context ID, and a target not configured as a link target. A design that trusted the link field would raise spurious events in those cases. It sets opposite filters on the address slot and its target, which exposes a design that applies the wrong slot's filter. It checks that a context-only hit disappears in privileged monitor mode. It also shows that refused writes and reserved bits leave the read-back words untouched.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int BP_DW    = 32;
    localparam int BP_LNKW  = 4;
    localparam int BP_BSELW = 4;

    typedef enum logic [1:0] {
        ML_ADDR      = 2'b00,
        ML_ADDR_LINK = 2'b01,
        ML_CTX       = 2'b10,
        ML_CTX_TGT   = 2'b11
    } ml_e;

    typedef struct packed {
        logic [BP_DW-1:0] ctrl;
        logic [BP_DW-1:0] val;
    } slot_t;

    // writable control bits common to all slots
    localparam logic [BP_DW-1:0] CTRL_BASE_MASK = 32'h001F_01E7;
    localparam logic [BP_DW-1:0] CTRL_MODE_BIT  = 32'h0020_0000;
endpackage

// File: rtl/bpm_regfile.sv
module bpm_regfile
    import bpm_pkg::*;
#(
    parameter int NPAIR     = 6,
    parameter int CTX_FIRST = 4,
    localparam int IDXW     = $clog2(NPAIR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [BP_DW-1:0]      wr_data,
    output slot_t [NPAIR-1:0]     slots
);
    typedef struct packed {
        slot_t [NPAIR-1:0] s;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [BP_DW-1:0] ctrl_mask(input int i);
        return (i >= CTX_FIRST) ? (CTRL_BASE_MASK | CTRL_MODE_BIT) : CTRL_BASE_MASK;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPAIR; i++) begin
            if (wr_en && (wr_idx == IDXW'(i))) begin
                if (wr_sel) st_d.s[i].val  = wr_data;
                else        st_d.s[i].ctrl = wr_data & ctrl_mask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slots = st_q.s;

    p_refused_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    for (genvar g = 0; g < NPAIR; g++) begin : g_chk
        p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.s[g].ctrl & ~ctrl_mask(g)) == '0);
    end
endmodule

// File: rtl/bpm_slot_cmp.sv
module bpm_slot_cmp
    import bpm_pkg::*;
#(
    parameter int NPAIR     = 6,
    parameter int CTX_FIRST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t [NPAIR-1:0] slots,
    input  logic [BP_DW-1:0]  iva,
    input  logic [BP_DW-1:0]  ctx,
    input  logic              priv,
    input  logic              mon,
    output logic [NPAIR-1:0]  raw
);
    logic [NPAIR-1:0] armed;   // slot is a live link target with a context match

    for (genvar g = 0; g < NPAIR; g++) begin : g_slot
        logic                en;
        logic [1:0]          filt;
        logic [BP_BSELW-1:0] bsel;
        logic [BP_LNKW-1:0]  tgt;
        ml_e                 ml;
        logic                pok, amatch, cmatch, tgt_ok;
        logic                unused_resv;

        assign en   = slots[g].ctrl[0];
        assign filt = slots[g].ctrl[2:1];
        assign bsel = slots[g].ctrl[8:5];
        assign tgt  = slots[g].ctrl[19:16];
        assign ml   = ml_e'(slots[g].ctrl[21:20]);
        assign unused_resv = ^{slots[g].ctrl[31:22], slots[g].ctrl[15:9], slots[g].ctrl[4:3]};

        assign pok    = priv ? filt[0] : filt[1];
        assign amatch = (iva[BP_DW-1:2] == slots[g].val[BP_DW-1:2]) && bsel[iva[1:0]];
        assign cmatch = (ctx == slots[g].val) && (bsel == '1);
        assign armed[g] = en && (ml == ML_CTX_TGT) && cmatch;

        always_comb begin
            tgt_ok = 1'b0;
            for (int j = CTX_FIRST; j < NPAIR; j++) begin
                if (j != g && tgt == BP_LNKW'(j)) tgt_ok = armed[j];
            end
        end

        always_comb begin
            unique case (ml)
                ML_ADDR:      raw[g] = en && amatch && pok;
                ML_ADDR_LINK: raw[g] = en && amatch && pok && tgt_ok;
                ML_CTX:       raw[g] = en && cmatch && pok && !(priv && mon);
                default:      raw[g] = 1'b0;
            endcase
        end

        p_ctx_supp_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ml == ML_CTX && priv && mon) |-> !raw[g]);
        p_self_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ml == ML_ADDR_LINK && tgt == BP_LNKW'(g)) |-> !raw[g]);
        p_link_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ml == ML_ADDR_LINK && raw[g]) |-> (tgt >= BP_LNKW'(CTX_FIRST) && tgt < BP_LNKW'(NPAIR)));
        p_tgt_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ml == ML_CTX_TGT) |-> !raw[g]);
    end
endmodule

// File: rtl/bpm_prio.sv
module bpm_prio #(
    parameter int NPAIR = 6,
    localparam int IDXW = $clog2(NPAIR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] raw,
    output logic             hit,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
            end
        end
    end

    p_idx_hits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> raw[idx]);
    p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((raw & ((NPAIR'(1) << idx) - NPAIR'(1))) == '0));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> (!hit && idx == '0));
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bpm_pkg::*;
#(
    parameter int NPAIR     = 6,
    parameter int CTX_FIRST = 4,
    localparam int IDXW     = $clog2(NPAIR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic             acc_sel,
    input  logic [IDXW-1:0]  acc_idx,
    input  logic [BP_DW-1:0] acc_wdata,
    output logic [BP_DW-1:0] acc_rdata,
    output logic             acc_undef,
    input  logic             priv,
    input  logic [1:0]       dbg_mode,
    input  logic [BP_DW-1:0] iva,
    input  logic [BP_DW-1:0] ctx,
    output logic             bp_hit,
    output logic [IDXW-1:0]  bp_idx
);
    slot_t [NPAIR-1:0] slots;
    logic [NPAIR-1:0]  raw;
    logic              mon, acc_ok;

    assign mon    = (dbg_mode == 2'b10);
    assign acc_ok = priv && mon && (acc_idx < IDXW'(NPAIR));
    assign acc_undef = acc_en && !acc_ok;

    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < NPAIR; i++) begin
            if (acc_en && acc_ok && acc_idx == IDXW'(i))
                acc_rdata = acc_sel ? slots[i].val : slots[i].ctrl;
        end
    end

    bpm_regfile #(.NPAIR(NPAIR), .CTX_FIRST(CTX_FIRST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(acc_en && acc_wr && acc_ok), .wr_sel(acc_sel),
        .wr_idx(acc_idx), .wr_data(acc_wdata), .slots(slots)
    );

    bpm_slot_cmp #(.NPAIR(NPAIR), .CTX_FIRST(CTX_FIRST)) u_cmp (
        .clk(clk), .rst_n(rst_n), .slots(slots),
        .iva(iva), .ctx(ctx), .priv(priv), .mon(mon), .raw(raw)
    );

    bpm_prio #(.NPAIR(NPAIR)) u_prio (
        .clk(clk), .rst_n(rst_n), .raw(raw), .hit(bp_hit), .idx(bp_idx)
    );

    p_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !(priv && mon)) |-> (acc_undef && acc_rdata == '0));
endmodule

// File: tb/bp_match_unit_tb.sv
module bp_match_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        acc_en = 0, acc_wr = 0, acc_sel = 0;
    logic [2:0]  acc_idx = 0;
    logic [31:0] acc_wdata = 0;
    logic [31:0] acc_rdata;
    logic        acc_undef;
    logic        priv = 1;
    logic [1:0]  dbg_mode = 2'b10;
    logic [31:0] iva = 0, ctx = 0;
    logic        bp_hit;
    logic [2:0]  bp_idx;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m_ctrl [6];
    logic [31:0] m_val  [6];

    always #5 clk = ~clk;

    bp_match_unit u_dut (.*);

    function automatic bit m_ok();
        return priv && dbg_mode == 2'b10 && acc_idx < 6;
    endfunction

    function automatic bit m_ctxm(int k);
        return m_ctrl[k][8:5] == 4'hF && m_val[k] == ctx;
    endfunction

    function automatic bit m_slot(int i);
        logic [31:0] c = m_ctrl[i];
        bit pass = priv ? c[1] : c[2];
        bit am   = (m_val[i][31:2] == iva[31:2]) && c[5 + iva[1:0]];
        int t    = c[19:16];
        if (!c[0]) return 0;
        if (c[21:20] == 2'b00) return am && pass;
        if (c[21:20] == 2'b10) return m_ctxm(i) && pass && !(priv && dbg_mode == 2'b10);
        if (c[21:20] == 2'b01) begin
            if (t != 4 && t != 5) return 0;
            if (t == i) return 0;
            if (m_ctrl[t][21:20] != 2'b11 || !m_ctrl[t][0] || !m_ctxm(t)) return 0;
            return am && pass;
        end
        return 0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: compare all outputs against the model, then apply the write
    task automatic cyc(string tag);
        int first = -1;
        logic [31:0] er;
        @(negedge clk); #1;
        for (int i = 5; i >= 0; i--) if (m_slot(i)) first = i;
        er = (acc_en && m_ok()) ? (acc_sel ? m_val[acc_idx] : m_ctrl[acc_idx]) : 32'h0;
        chk(tag, "bp_hit", {31'b0, bp_hit}, {31'b0, first >= 0});
        chk(tag, "bp_idx", {29'b0, bp_idx}, (first >= 0) ? first : 0);
        chk(tag, "acc_undef", {31'b0, acc_undef}, {31'b0, acc_en && !m_ok()});
        chk(tag, "acc_rdata", acc_rdata, er);
        @(posedge clk);
        if (rst_n && acc_en && acc_wr && m_ok()) begin
            if (acc_sel) m_val[acc_idx] = acc_wdata;
            else m_ctrl[acc_idx] = acc_wdata & ((acc_idx >= 4) ? 32'h003F01E7 : 32'h001F01E7);
        end
        #1;
    endtask

    task automatic wr(bit sel, int idx, logic [31:0] d, string tag);
        acc_en = 1; acc_wr = 1; acc_sel = sel; acc_idx = idx[2:0]; acc_wdata = d;
        cyc(tag);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd(bit sel, int idx, logic [31:0] exp, string tag);
        acc_en = 1; acc_wr = 0; acc_sel = sel; acc_idx = idx[2:0];
        @(negedge clk); #1;
        chk(tag, "readback", acc_rdata, exp);
        cyc(tag);
        acc_en = 0;
    endtask

    task automatic at(logic [31:0] a, logic [31:0] c, bit p, string tag);
        iva = a; ctx = c; priv = p; cyc(tag);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin m_ctrl[i] = 0; m_val[i] = 0; end
        repeat (2) @(posedge clk); #1;
        rst_n = 1; #1;
        cyc("R1");
        rd(0, 0, 32'h0, "R1");
        rd(1, 5, 32'h0, "R1");
        at(32'h0, 32'h0, 1, "R1");

        // R4: enable in the same cycle the address matches
        wr(1, 0, 32'h0000_1000, "R4");
        iva = 32'h1000;
        wr(0, 0, 32'h0000_01E7, "R4");
        cyc("R4");

        // R5 byte lanes
        for (int b = 0; b < 4; b++) at(32'h1000 + b, 0, 1, "R5");
        at(32'h1004, 0, 1, "R5");
        wr(0, 0, 32'h0000_0067, "R5");
        for (int b = 0; b < 4; b++) at(32'h1000 + b, 0, 1, "R5");
        wr(0, 0, 32'h0000_0007, "R5");
        at(32'h1000, 0, 1, "R5");

        // R6 privilege filter
        wr(0, 0, 32'h0000_01E3, "R6");
        at(32'h1000, 0, 1, "R6"); at(32'h1000, 0, 0, "R6");
        priv = 1; wr(0, 0, 32'h0000_01E5, "R6");
        at(32'h1000, 0, 1, "R6"); at(32'h1000, 0, 0, "R6");
        priv = 1; wr(0, 0, 32'h0000_01E1, "R6");
        at(32'h1000, 0, 1, "R6"); at(32'h1000, 0, 0, "R6");
        priv = 1; wr(0, 0, 32'h0, "R6");

        // R7 context-only
        wr(1, 4, 32'h0000_0055, "R7");
        wr(0, 4, 32'h0020_01E7, "R7");
        at(32'h0, 32'h55, 1, "R7");
        dbg_mode = 2'b00;
        at(32'h0, 32'h55, 1, "R7"); at(32'h0, 32'h55, 0, "R7"); at(32'h0, 32'h56, 0, "R7");
        dbg_mode = 2'b10; priv = 1;
        wr(0, 4, 32'h0020_00E7, "R7");
        dbg_mode = 2'b00; at(32'h0, 32'h55, 0, "R7");
        dbg_mode = 2'b10; priv = 1;

        // R11 / R8 linking
        wr(0, 4, 32'h0030_01E3, "R11");
        at(32'h0, 32'h55, 1, "R11");
        wr(1, 1, 32'h0000_2000, "R8");
        wr(0, 1, 32'h0014_01E5, "R8");
        at(32'h2000, 32'h55, 0, "R8");
        at(32'h2000, 32'h54, 0, "R8");
        at(32'h2000, 32'h55, 1, "R8");
        priv = 1; wr(0, 4, 32'h0030_01E2, "R8");
        at(32'h2000, 32'h55, 0, "R8");
        priv = 1; wr(0, 4, 32'h0030_01E3, "R8");

        // R9 invalid targets
        wr(0, 1, 32'h0011_01E7, "R9"); at(32'h2000, 32'h55, 1, "R9");
        priv = 1; wr(0, 1, 32'h0013_01E7, "R9"); at(32'h2000, 32'h55, 1, "R9");
        wr(1, 5, 32'h0000_0055, "R9");
        wr(0, 5, 32'h0020_01E7, "R9");
        wr(0, 1, 32'h0015_01E7, "R9"); at(32'h2000, 32'h55, 1, "R9");
        wr(0, 1, 32'h0014_01E7, "R9"); at(32'h2000, 32'h55, 1, "R9");

        // R10 lowest index wins
        wr(1, 2, 32'h0000_2000, "R10");
        wr(0, 2, 32'h0000_01E7, "R10");
        wr(1, 0, 32'h0000_2000, "R10");
        at(32'h2000, 32'h55, 1, "R10");
        wr(0, 0, 32'h0000_01E7, "R10");
        at(32'h2000, 32'h55, 1, "R10");
        at(32'h3000, 32'h00, 1, "R10");

        // R3 reserved bits
        wr(0, 3, 32'hFFFF_FFFF, "R3");
        rd(0, 3, 32'h001F_01E7, "R3");
        wr(0, 5, 32'hFFFF_FFFF, "R3");
        rd(0, 5, 32'h003F_01E7, "R3");
        at(32'h2000, 32'h55, 1, "R3");

        // R2 refused accesses
        priv = 0; wr(0, 0, 32'h0, "R2");
        priv = 1; dbg_mode = 2'b01; wr(1, 2, 32'h0, "R2");
        dbg_mode = 2'b10; wr(0, 6, 32'hFFFF_FFFF, "R2");
        rd(0, 7, 32'h0, "R2");
        rd(0, 0, 32'h0000_01E7, "R2");
        rd(1, 2, 32'h0000_2000, "R2");
        at(32'h2000, 32'h55, 1, "R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule